// File: doc/BRIEF.md
# ADC Sample Buffer with Counted Interrupt

This block sits between an analog-to-digital converter and a host register bus. Each conversion strobe pushes one 16-bit word into an on-chip FIFO. The word carries the conversion result in its upper bits and three marker lines in its low bits. The host drains the FIFO through a small synchronous register port, and it can poll occupancy flags to do so.

A self-reloading 16-bit down-counter counts accepted samples and raises an interrupt source every N samples. A separate source fires on every accepted FIFO write. Both sources latch as pending bits. Enable bits decide which pending bits are visible and which drive the interrupt line. Writing a mask clears the matching pending bits.

An acquisition state machine controls the `conv_halt` output. It has three states:
- `ACQ_RUN`: samples are accepted.
- `ACQ_FULL`: the FIFO holds DEPTH words.
- `ACQ_STOP`: the sample counter expired while stop mode was selected.

The transitions are:
- RUN to FULL when the fill level reaches DEPTH.
- FULL to RUN when a pop frees a slot.
- RUN to STOP on counter expiry in stop mode.
- Any state to RUN on a FIFO-clear write.

When a strobe arrives while the FIFO is full, the sample is dropped and a sticky overrun flag is set.

Top module: `adc_sample_buffer`

## Requirements
- R1: The word stored for a strobe is {conv_data (13 bits) in [15:3], conv_marker in [2:0]}. Reads of address 0 return the words in arrival order, and each read of a non-empty FIFO removes one word. Read data appears on bus_rdata in the cycle after the read request and holds until the next read.
- R2: Address 1 reads the status word. Bit 8 is not-empty. Bit 9 is half-empty, which is 1 while the fill level is below DEPTH/2. Bit 10 is not-full. Bit 0 is the overrun flag and bit 1 mirrors conv_halt.
- R3: When the FIFO holds DEPTH words, conv_halt is 1. A strobe in that condition is dropped and sets the overrun flag. The flag stays set until a write to address 7, and reading address 7 returns it in bit 0.
- R4: A read of address 0 while the FIFO is empty returns the last word read and changes no pointer.
- R5: Writing V to address 4 loads both the reload value and the counter. Source bit 4 becomes pending on every (V+1)-th accepted sample, and the counter reloads itself. Address 4 reads back V.
- R6: Address 5, bit 0 is the counter mode: 1 means interrupt only, 0 means the acquisition also halts on expiry. A halt on expiry asserts conv_halt and ignores further strobes until a write to address 6.
- R7: Source bit 0 becomes pending on every accepted sample. Address 2 holds the enables, and only bits 0 and 4 are kept. Address 3 reads pending AND enable, and irq is 1 exactly when that value is nonzero.
- R8: Writing a mask to address 3 clears the pending bits that are set in the mask. A source event in the same cycle wins.
- R9: Any write to address 6 empties the FIFO, discards a same-cycle strobe, and returns the state machine to ACQ_RUN.
- R10: After reset, the FIFO is empty and no source is pending or enabled. The reload value is 0xFFFF, the mode is 1, and irq and conv_halt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_strobe | input | 1 | One-cycle pulse: a conversion result is ready |
| conv_data | input | 13 | Conversion result field |
| conv_marker | input | 3 | Marker lines stored with the sample |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| conv_halt | output | 1 | Tells the converter to stop |

## Verification
The bench fills the FIFO to the brim and pushes one strobe beyond it. A design that accepted that word, or forgot the overrun flag, would show a wrong last word or a zero in status bit 0. It also drains the FIFO past empty. A pointer that wrapped there would return stale or foreign data instead of the last word.

The counter is checked on its first and its reloaded period. An off-by-one load would fire one sample early or late. Status reads are taken with a source pending but not enabled, to catch a design that leaks unmasked bits. Stop mode is probed by strobing after expiry and counting what the host can drain.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;

    typedef enum logic [1:0] {
        ACQ_RUN  = 2'd0,
        ACQ_FULL = 2'd1,
        ACQ_STOP = 2'd2
    } acq_state_t;

    localparam logic [3:0] A_DATA   = 4'd0;
    localparam logic [3:0] A_STAT   = 4'd1;
    localparam logic [3:0] A_IEN    = 4'd2;
    localparam logic [3:0] A_ISTAT  = 4'd3;
    localparam logic [3:0] A_RELOAD = 4'd4;
    localparam logic [3:0] A_MODE   = 4'd5;
    localparam logic [3:0] A_FCLR   = 4'd6;
    localparam logic [3:0] A_OVR    = 4'd7;

    localparam int SRC_WRITE = 0;
    localparam int SRC_COUNT = 4;

    localparam int ST_OVR    = 0;
    localparam int ST_HALT   = 1;
    localparam int ST_NEMPTY = 8;
    localparam int ST_HEMPTY = 9;
    localparam int ST_NFULL  = 10;

endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 1024,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [CNT_W-1:0]  fill,
    output logic              empty,
    output logic              full,
    output logic              half_empty
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr_q;
    logic [PTR_W-1:0]  rptr_q;
    logic [CNT_W-1:0]  fill_q;
    logic              do_push;
    logic              do_pop;

    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr_q] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else begin
            if (do_push) begin
                wptr_q <= wptr_q + PTR_W'(1);
            end
            if (do_pop) begin
                rptr_q <= rptr_q + PTR_W'(1);
            end
            fill_q <= fill_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assign head       = mem[rptr_q];
    assign fill       = fill_q;
    assign empty      = (fill_q == '0);
    assign full       = (fill_q == CNT_W'(DEPTH));
    assign half_empty = (fill_q < CNT_W'(DEPTH / 2));

endmodule

// File: rtl/sample_counter.sv
module sample_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          expire,
    output logic [CW-1:0] reload_val
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload_q;

    assign expire     = tick && (cnt_q == '0);
    assign reload_val = reload_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '1;
            reload_q <= '1;
        end else if (load) begin
            cnt_q    <= load_val;
            reload_q <= load_val;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - CW'(1);
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    IMPL = 16'h0011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] status,
    output logic         irq
);

    logic [W-1:0] pend_q;
    logic [W-1:0] kill;

    assign kill = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= ((pend_q & ~kill) | set_vec) & IMPL;
            if (en_we) begin
                en_q <= en_wdata & IMPL;
            end
        end
    end

    assign status = pend_q & en_q;
    assign irq    = |status;

endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer
    import adc_buf_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 16,
    parameter int MARK_W = 3,
    parameter int SCNT_W = 16,
    parameter int ADDR_W = 4,
    localparam int DATA_W = WORD_W - MARK_W,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_strobe,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [MARK_W-1:0] conv_marker,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              conv_halt
);

    acq_state_t state_q, state_nxt;

    logic              wr, rd;
    logic              fclr, ovr_clr, ien_we, iclr_we, reload_we, mode_we;
    logic              push, pop, expire;
    logic              empty, full, half_empty;
    logic [CNT_W-1:0]  fill_lvl, fill_nxt;
    logic [WORD_W-1:0] head, last_q, rdata_q, rd_mux;
    logic [WORD_W-1:0] ien_q, istat, set_vec;
    logic [SCNT_W-1:0] reload_val;
    logic              ovr_q, keep_mode_q;

    assign wr        = bus_en && bus_we;
    assign rd        = bus_en && !bus_we;
    assign fclr      = wr && (bus_addr == ADDR_W'(A_FCLR));
    assign ovr_clr   = wr && (bus_addr == ADDR_W'(A_OVR));
    assign ien_we    = wr && (bus_addr == ADDR_W'(A_IEN));
    assign iclr_we   = wr && (bus_addr == ADDR_W'(A_ISTAT));
    assign reload_we = wr && (bus_addr == ADDR_W'(A_RELOAD));
    assign mode_we   = wr && (bus_addr == ADDR_W'(A_MODE));

    assign push = conv_strobe && (state_q == ACQ_RUN) && !fclr;
    assign pop  = rd && (bus_addr == ADDR_W'(A_DATA)) && !empty && !fclr;
    assign fill_nxt = fill_lvl + CNT_W'(push) - CNT_W'(pop);

    sample_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fclr),
        .push       (push),
        .wdata      ({conv_data, conv_marker}),
        .pop        (pop),
        .head       (head),
        .fill       (fill_lvl),
        .empty      (empty),
        .full       (full),
        .half_empty (half_empty)
    );

    sample_counter #(.CW(SCNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (reload_we),
        .load_val   (bus_wdata[SCNT_W-1:0]),
        .tick       (push),
        .expire     (expire),
        .reload_val (reload_val)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[SRC_WRITE] = push;
        set_vec[SRC_COUNT] = expire;
    end

    irq_ctrl #(.W(WORD_W), .IMPL(WORD_W'(16'h0011))) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (iclr_we),
        .clr_mask (bus_wdata),
        .en_we    (ien_we),
        .en_wdata (bus_wdata),
        .en_q     (ien_q),
        .status   (istat),
        .irq      (irq)
    );

    // acquisition state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACQ_RUN;
        end else begin
            state_q <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        if (fclr) begin
            state_nxt = ACQ_RUN;
        end else begin
            unique case (state_q)
                ACQ_RUN: begin
                    if (expire && !keep_mode_q) begin
                        state_nxt = ACQ_STOP;
                    end else if (fill_nxt == CNT_W'(DEPTH)) begin
                        state_nxt = ACQ_FULL;
                    end
                end
                ACQ_FULL: begin
                    if (fill_nxt != CNT_W'(DEPTH)) begin
                        state_nxt = ACQ_RUN;
                    end
                end
                ACQ_STOP: state_nxt = ACQ_STOP;
                default:  state_nxt = ACQ_RUN;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        unique case (state_q)
            ACQ_RUN:  conv_halt = 1'b0;
            ACQ_FULL: conv_halt = 1'b1;
            ACQ_STOP: conv_halt = 1'b1;
            default:  conv_halt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q       <= 1'b0;
            keep_mode_q <= 1'b1;
            last_q      <= '0;
            rdata_q     <= '0;
        end else begin
            if (conv_strobe && full && !fclr) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
            if (mode_we) begin
                keep_mode_q <= bus_wdata[0];
            end
            if (pop) begin
                last_q <= head;
            end
            if (rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            ADDR_W'(A_DATA):   rd_mux = empty ? last_q : head;
            ADDR_W'(A_STAT): begin
                rd_mux[ST_OVR]    = ovr_q;
                rd_mux[ST_HALT]   = conv_halt;
                rd_mux[ST_NEMPTY] = !empty;
                rd_mux[ST_HEMPTY] = half_empty;
                rd_mux[ST_NFULL]  = !full;
            end
            ADDR_W'(A_IEN):    rd_mux = ien_q;
            ADDR_W'(A_ISTAT):  rd_mux = istat;
            ADDR_W'(A_RELOAD): rd_mux = WORD_W'(reload_val);
            ADDR_W'(A_MODE):   rd_mux[0] = keep_mode_q;
            ADDR_W'(A_OVR):    rd_mux[0] = ovr_q;
            default:           rd_mux = '0;
        endcase
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/adc_buf_checker.sv
module adc_buf_checker
    import adc_buf_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 4,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_strobe,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              conv_halt,
    input logic              irq,
    input logic [CNT_W-1:0]  fill,
    input logic              ovr,
    input logic [15:0]       ien
);

    logic fclr_w;
    assign fclr_w = bus_en && bus_we && (bus_addr == ADDR_W'(A_FCLR));

    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R3
    full_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(DEPTH)) |-> conv_halt);

    // R3
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_strobe && fill == CNT_W'(DEPTH) && !fclr_w) |=> ovr);

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_halt && !bus_en) |=> $stable(fill));

    // R7
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((ien & 16'h0011) != 16'h0000));

endmodule

bind adc_sample_buffer adc_buf_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_strobe (conv_strobe),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .conv_halt   (conv_halt),
    .irq         (irq),
    .fill        (fill_lvl),
    .ovr         (ovr_q),
    .ien         (ien_q)
);

// File: tb/test_adc_sample_buffer.sv
module test_adc_sample_buffer;

    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_strobe = 1'b0;
    logic [12:0] conv_data = '0;
    logic [2:0]  conv_marker = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic        conv_halt;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    adc_sample_buffer #(.DEPTH(DEPTH)) i_adc_sample_buffer (
        .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe),
        .conv_data(conv_data), .conv_marker(conv_marker),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .conv_halt(conv_halt)
    );

    // word = {result[12:0], marker[2:0]}
    localparam logic [15:0] VEC [8] = '{
        16'h0000, 16'hFFFF, 16'h1235, 16'h8001,
        16'h7FF8, 16'hA5A2, 16'h5A5C, 16'h0F0F
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        @(negedge clk);
        conv_strobe = 1'b1;
        conv_data   = w[15:3];
        conv_marker = w[2:0];
        @(negedge clk);
        conv_strobe = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] wordof(input int i);
        logic [15:0] v;
        v = 16'(i);
        return {v[12:0], v[2:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int errs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk("R10 irq", {15'd0, irq}, 16'h0000);
        chk("R10 halt", {15'd0, conv_halt}, 16'h0000);
        rd(4'd1, d); chk("R10/R2 status", d, 16'h0600);
        rd(4'd2, d); chk("R10 enable", d, 16'h0000);
        rd(4'd4, d); chk("R10 reload", d, 16'hFFFF);
        rd(4'd5, d); chk("R10 mode", d, 16'h0001);

        // R1 vector table: push then pop in order
        for (int i = 0; i < 8; i++) push(VEC[i]);
        rd(4'd1, d); chk("R2 status nonempty", d, 16'h0700);
        for (int i = 0; i < 8; i++) begin
            rd(4'd0, d); chk("R1 fifo word", d, VEC[i]);
        end
        // R4 empty read repeats last
        rd(4'd0, d); chk("R4 empty read", d, VEC[7]);
        rd(4'd0, d); chk("R4 empty read again", d, VEC[7]);
        rd(4'd1, d); chk("R4 still empty", d, 16'h0600);

        // R7 enable keeps only bits 0 and 4
        wr(4'd2, 16'hFFFF);
        rd(4'd2, d); chk("R7 enable bits", d, 16'h0011);

        // R5 counter: N=3
        wr(4'd2, 16'h0010);
        wr(4'd4, 16'h0002);
        wr(4'd3, 16'hFFFF);
        rd(4'd4, d); chk("R5 reload readback", d, 16'h0002);
        push(16'h0008); push(16'h0010);
        chk("R5 no irq after 2", {15'd0, irq}, 16'h0000);
        rd(4'd3, d); chk("R7 masked status", d, 16'h0000);
        push(16'h0018);
        chk("R5 irq after 3", {15'd0, irq}, 16'h0001);
        rd(4'd3, d); chk("R5 status bit4", d, 16'h0010);
        wr(4'd3, 16'h0010);
        chk("R8 cleared", {15'd0, irq}, 16'h0000);
        push(16'h0020); push(16'h0028);
        chk("R5 reload no irq", {15'd0, irq}, 16'h0000);
        push(16'h0030);
        chk("R5 reload irq", {15'd0, irq}, 16'h0001);
        wr(4'd3, 16'h0011);

        // R7 write source
        wr(4'd2, 16'h0001);
        chk("R7 irq idle", {15'd0, irq}, 16'h0000);
        push(16'h0038);
        chk("R7 write irq", {15'd0, irq}, 16'h0001);
        rd(4'd3, d); chk("R7 status bit0", d, 16'h0001);
        wr(4'd3, 16'h0001);
        chk("R8 clear bit0", {15'd0, irq}, 16'h0000);
        wr(4'd2, 16'h0000);

        // R9 clear
        wr(4'd6, 16'h0000);
        rd(4'd1, d); chk("R9 cleared", d, 16'h0600);

        // R6 stop mode, N=2
        wr(4'd5, 16'h0000);
        wr(4'd4, 16'h0001);
        push(16'h1111); push(16'h2222);
        chk("R6 halted", {15'd0, conv_halt}, 16'h0001);
        push(16'h3333);
        rd(4'd0, d); chk("R6 first", d, 16'h1111);
        rd(4'd0, d); chk("R6 second", d, 16'h2222);
        rd(4'd1, d); chk("R6 strobe ignored", d, 16'h0602);
        wr(4'd6, 16'h0000);
        chk("R6/R9 resume", {15'd0, conv_halt}, 16'h0000);
        wr(4'd5, 16'h0001);

        // R2/R3 full
        for (int i = 0; i < DEPTH / 2 - 1; i++) push(wordof(i));
        rd(4'd1, d); chk("R2 half-empty set", d, 16'h0700);
        push(wordof(DEPTH / 2 - 1));
        rd(4'd1, d); chk("R2 half-empty clear", d, 16'h0500);
        for (int i = DEPTH / 2; i < DEPTH; i++) push(wordof(i));
        chk("R3 halt full", {15'd0, conv_halt}, 16'h0001);
        rd(4'd1, d); chk("R3 status full", d, 16'h0102);
        push(16'hBEEF);
        rd(4'd1, d); chk("R3 overrun", d, 16'h0103);
        rd(4'd7, d); chk("R3 overrun reg", d, 16'h0001);
        rd(4'd0, d); chk("R3 first word", d, wordof(0));
        chk("R3 halt released", {15'd0, conv_halt}, 16'h0000);
        rd(4'd1, d); chk("R3 overrun sticky", d, 16'h0501);
        wr(4'd7, 16'h0000);
        rd(4'd7, d); chk("R3 overrun cleared", d, 16'h0000);
        errs = 0;
        for (int i = 1; i < DEPTH; i++) begin
            rd(4'd0, d);
            if (d !== wordof(i)) errs++;
        end
        chk("R1/R3 drained order", 16'(errs), 16'h0000);
        rd(4'd1, d); chk("R3 dropped word absent", d, 16'h0600);

        // R10 reset mid-run
        wr(4'd2, 16'h0011);
        push(16'h4444);
        chk("R10 pre irq", {15'd0, irq}, 16'h0001);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 irq after reset", {15'd0, irq}, 16'h0000);
        rd(4'd1, d); chk("R10 status after reset", d, 16'h0600);
        rd(4'd2, d); chk("R10 enable after reset", d, 16'h0000);
        rd(4'd4, d); chk("R10 reload after reset", d, 16'hFFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule